// File: doc/BRIEF.md
# Pulse Height Ramp Sequencer

This block steps one pulser's DAC pulse height through a ramp on its own, so the host does not have to rewrite the setting for every level. The host presents a start level, an end level, the number of levels and the number of triggers to spend at each level, then pulses `start`. The block drives the start level at once. It counts the triggers sent to its pulser. When the requested count at a level is reached, it moves to the next level. After the count at the end level is complete, it raises `done`.

The spacing between levels is the integer quotient of the distance between the two end levels and the number of levels minus one. The end level is always written exactly, so any remainder from the division falls into the last step. Ramps may go up or down. Every pulser has its own trigger line, so each pulser gets its own instance of this block with its own count.

All pins are plain control and status signals. `trig` is sampled as a one-cycle pulse on each clock edge where it is high. No pin carries back-pressure: the block accepts a trigger on every cycle and never stalls the trigger source. The consumer of `dac_out` must take each new level in the cycle that `dac_update` marks.

Top module: `ramp_sequencer`

## Requirements
- R1: After reset, `dac_out` is 0 and `dac_update`, `busy`, `done` and `cfg_err` are all low.
- R2: A `start` while not busy, with `num_steps` and `events_per_step` both non-zero, captures the configuration. In the next cycle `dac_out` equals `init_val`, `busy` is high and `dac_update` is high.
- R3: Level k (counted from 0) that is not the last equals `init_val + k*floor((final_val-init_val)/(num_steps-1))` when `final_val >= init_val`. Otherwise it equals `init_val - k*floor((init_val-final_val)/(num_steps-1))`.
- R4: The last level, number `num_steps-1`, is exactly `final_val`.
- R5: While busy, the trigger that completes `events_per_step` counted triggers at the current level moves `dac_out` to the next level on the following cycle. Triggers are counted only while busy.
- R6: `dac_update` is high for one cycle with each level written, including the first load. `dac_out` never changes without it.
- R7: The trigger that completes the count at the last level drops `busy` and raises `done` in the next cycle. `done` stays high, `dac_out` holds, and further triggers are ignored until a new `start` or `abort`.
- R8: With `num_steps` = 1, the block holds `init_val` for one count of triggers and then finishes.
- R9: A `start` with `num_steps` = 0 or `events_per_step` = 0 loads nothing. It raises `cfg_err` and leaves `busy` and `done` low. `cfg_err` clears on the next accepted start or on `abort`.
- R10: `abort` takes priority over every other input. It drops `busy` and `done` in the next cycle, and `dac_out` keeps its value.
- R11: A `start` while busy is ignored, and the ramp in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a ramp with the presented configuration |
| abort | input | 1 | Return to idle at once |
| init_val | input | 18 | First DAC level |
| final_val | input | 18 | Last DAC level |
| num_steps | input | 8 | Number of levels in the ramp |
| events_per_step | input | 16 | Triggers to count at each level |
| trig | input | 1 | Trigger pulse sent to this pulser |
| dac_out | output | 18 | Current DAC pulse height |
| dac_update | output | 1 | One-cycle strobe: `dac_out` was written |
| busy | output | 1 | Ramp in progress |
| done | output | 1 | Ramp complete |
| cfg_err | output | 1 | Last start was rejected |

## Verification
A wrong trigger count shows up as a level change one or more triggers early or late, seen on `dac_out` and `dac_update` in the cycle after the trigger concerned. A wrong increment or direction shows on the second level. A lost remainder is caught at the last level, where the output must equal `final_val` exactly. A bad level index shows as `done` arriving early or late, or as a missing final value. The bench model predicts every output on every clock, so any such divergence is reported in the first cycle it appears.

// File: rtl/ramp_pkg.sv
package ramp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } ramp_state_t;
endpackage

// File: rtl/ramp_step_calc.sv
module ramp_step_calc #(
  parameter int DAC_W  = 18,
  parameter int STEP_W = 8
) (
  input  logic [DAC_W-1:0]  init_val,
  input  logic [DAC_W-1:0]  final_val,
  input  logic [STEP_W-1:0] num_steps,
  output logic [DAC_W-1:0]  step_inc,
  output logic              step_down
);
  localparam int PAD_W = DAC_W - STEP_W;

  logic [DAC_W-1:0]  span;
  logic [STEP_W-1:0] gaps;
  logic [DAC_W-1:0]  divisor;

  always_comb begin
    step_down = (final_val < init_val);
    span      = step_down ? (init_val - final_val) : (final_val - init_val);
    gaps      = (num_steps > STEP_W'(1)) ? (num_steps - STEP_W'(1)) : STEP_W'(1);
    divisor   = {{PAD_W{1'b0}}, gaps};
    step_inc  = span / divisor;
  end

  // R3: the quotient times the gap count never exceeds the span
  always_comb begin
    if (num_steps > STEP_W'(1))
      a_r3_inc_fits_span: assert ((step_inc * divisor) <= span);
  end
endmodule

// File: rtl/ramp_dwell_counter.sv
module ramp_dwell_counter #(
  parameter int EVT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             trig,
  input  logic [EVT_W-1:0] limit,
  output logic             dwell_last
);
  logic [EVT_W-1:0] cnt_q;
  logic             count_en;

  assign count_en   = active & trig;
  assign dwell_last = count_en && (cnt_q == limit - EVT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (!active || dwell_last) cnt_q <= '0;
    else if (count_en)           cnt_q <= cnt_q + EVT_W'(1);
  end

  // R5: the count at a level stays below the programmed dwell
  a_r5_cnt_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt_q < limit));
  // R5: no count is kept while not running
  a_r5_idle_cnt_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !$past(active)) |-> (cnt_q == '0));
endmodule

// File: rtl/ramp_sequencer.sv
module ramp_sequencer
  import ramp_pkg::*;
#(
  parameter int DAC_W  = 18,
  parameter int STEP_W = 8,
  parameter int EVT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [DAC_W-1:0]  init_val,
  input  logic [DAC_W-1:0]  final_val,
  input  logic [STEP_W-1:0] num_steps,
  input  logic [EVT_W-1:0]  events_per_step,
  input  logic              trig,
  output logic [DAC_W-1:0]  dac_out,
  output logic              dac_update,
  output logic              busy,
  output logic              done,
  output logic              cfg_err
);
  ramp_state_t       state_q;
  logic [DAC_W-1:0]  dac_q, fin_q, inc_q;
  logic              down_q, upd_q, err_q;
  logic [STEP_W-1:0] lvl_q, last_lvl_q, lvl_nxt;
  logic [EVT_W-1:0]  evts_q;
  logic [DAC_W-1:0]  calc_inc;
  logic              calc_down;
  logic              cfg_ok, running, dwell_last;

  ramp_step_calc #(.DAC_W(DAC_W), .STEP_W(STEP_W)) u_calc (
    .init_val  (init_val),
    .final_val (final_val),
    .num_steps (num_steps),
    .step_inc  (calc_inc),
    .step_down (calc_down)
  );

  assign running = (state_q == ST_RUN);

  ramp_dwell_counter #(.EVT_W(EVT_W)) u_dwell (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (running & ~abort),
    .trig       (trig),
    .limit      (evts_q),
    .dwell_last (dwell_last)
  );

  assign cfg_ok  = (num_steps != '0) && (events_per_step != '0);
  assign lvl_nxt = lvl_q + STEP_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      dac_q      <= '0;
      fin_q      <= '0;
      inc_q      <= '0;
      down_q     <= 1'b0;
      upd_q      <= 1'b0;
      err_q      <= 1'b0;
      lvl_q      <= '0;
      last_lvl_q <= '0;
      evts_q     <= '0;
    end else begin
      upd_q <= 1'b0;
      if (abort) begin
        state_q <= ST_IDLE;
        err_q   <= 1'b0;
      end else if (!running) begin
        if (start) begin
          if (cfg_ok) begin
            state_q    <= ST_RUN;
            dac_q      <= init_val;
            fin_q      <= final_val;
            inc_q      <= calc_inc;
            down_q     <= calc_down;
            lvl_q      <= '0;
            last_lvl_q <= num_steps - STEP_W'(1);
            evts_q     <= events_per_step;
            upd_q      <= 1'b1;
            err_q      <= 1'b0;
          end else begin
            state_q <= ST_IDLE;
            err_q   <= 1'b1;
          end
        end
      end else if (dwell_last) begin
        if (lvl_q == last_lvl_q) begin
          state_q <= ST_DONE;
        end else begin
          lvl_q <= lvl_nxt;
          upd_q <= 1'b1;
          if (lvl_nxt == last_lvl_q) dac_q <= fin_q;
          else if (down_q)           dac_q <= dac_q - inc_q;
          else                       dac_q <= dac_q + inc_q;
        end
      end
    end
  end

  assign dac_out    = dac_q;
  assign dac_update = upd_q;
  assign busy       = running;
  assign done       = (state_q == ST_DONE);
  assign cfg_err    = err_q;

  // R6: every change of the output level is flagged
  a_r6_change_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_out != $past(dac_out)) |-> dac_update);
  // R7: running and finished never overlap
  a_r7_done_busy_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));
  // R7: the level holds while finished
  a_r7_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> $stable(dac_out));
  // R10: abort leaves the block idle in the next cycle
  a_r10_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $past(abort) |-> (!busy && !done));
  // R9: a rejected start never starts a ramp
  a_r9_err_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !busy);
  // R4: the level index never passes the last level
  a_r4_lvl_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (lvl_q <= last_lvl_q));
endmodule

// File: tb/ramp_sequencer_tb.sv
module ramp_sequencer_tb;
  localparam int DW = 18;
  localparam int SW = 8;
  localparam int EW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, abort = 1'b0, trig = 1'b0;
  logic [DW-1:0] init_val = '0, final_val = '0;
  logic [SW-1:0] num_steps = '0;
  logic [EW-1:0] events_per_step = '0;
  logic [DW-1:0] dac_out;
  logic dac_update, busy, done, cfg_err;

  int n_cmp = 0, n_bad = 0;

  always #5 clk = ~clk;

  ramp_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .init_val(init_val), .final_val(final_val), .num_steps(num_steps),
    .events_per_step(events_per_step), .trig(trig),
    .dac_out(dac_out), .dac_update(dac_update), .busy(busy),
    .done(done), .cfg_err(cfg_err)
  );

  // behavioural reference: 0 idle, 1 running, 2 finished
  int m_state = 0, m_dac = 0, m_upd = 0, m_err = 0;
  int m_lvl = 0, m_cnt = 0, m_init = 0, m_fin = 0, m_steps = 0, m_evts = 0;

  function automatic int level_value(int k);
    int span, inc;
    if (k == m_steps - 1) return m_fin;
    span = (m_fin >= m_init) ? m_fin - m_init : m_init - m_fin;
    inc  = span / (m_steps - 1);
    return (m_fin >= m_init) ? m_init + k * inc : m_init - k * inc;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_dac = 0; m_upd = 0; m_err = 0; m_lvl = 0; m_cnt = 0;
    end else begin
      m_upd = 0;
      if (abort) begin
        m_state = 0; m_err = 0;
      end else if (m_state != 1) begin
        if (start) begin
          if (num_steps == 0 || events_per_step == 0) begin
            m_err = 1; m_state = 0;
          end else begin
            m_init = int'(init_val); m_fin = int'(final_val);
            m_steps = int'(num_steps); m_evts = int'(events_per_step);
            m_lvl = 0; m_cnt = 0; m_dac = m_init; m_upd = 1;
            m_err = 0; m_state = 1;
          end
        end
      end else if (trig) begin
        m_cnt++;
        if (m_cnt == m_evts) begin
          m_cnt = 0;
          if (m_lvl == m_steps - 1) m_state = 2;
          else begin
            m_lvl++;
            m_dac = level_value(m_lvl);
            m_upd = 1;
          end
        end
      end
    end
  end

  task automatic cmp(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  // every-cycle comparison, away from the edge
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      cmp("R3/R4 dac_out", int'(dac_out), m_dac);
      cmp("R6 dac_update", int'(dac_update), m_upd);
      cmp("R5/R11 busy", int'(busy), (m_state == 1) ? 1 : 0);
      cmp("R7 done", int'(done), (m_state == 2) ? 1 : 0);
      cmp("R9 cfg_err", int'(cfg_err), m_err);
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic go(int iv, int fv, int st, int ev);
    init_val = DW'(iv); final_val = DW'(fv);
    num_steps = SW'(st); events_per_step = EW'(ev);
    start = 1'b1; tick(); start = 1'b0; tick();
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      trig = 1'b1; tick(); trig = 1'b0; tick();
    end
  endtask

  initial begin
    #1_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    tick(); tick();
    cmp("R1 reset dac_out", int'(dac_out), 0);
    cmp("R1 reset flags", int'({dac_update, busy, done, cfg_err}), 0);
    rst_n = 1'b1; tick();

    // ascending ramp: 100,133,166,200 with 3 triggers each
    go(100, 200, 4, 3);
    cmp("R2 first level", int'(dac_out), 100);
    pulses(2);
    cmp("R5 no advance before count", int'(dac_out), 100);
    pulses(1);
    cmp("R3 second level", int'(dac_out), 133);
    start = 1'b1; init_val = DW'(5); tick(); start = 1'b0; // R11
    pulses(6);
    cmp("R4 final exact", int'(dac_out), 200);
    cmp("R11 restart ignored", int'(busy), 1);
    pulses(3);
    cmp("R7 done raised", int'(done), 1);
    pulses(4);
    cmp("R7 triggers ignored", int'(dac_out), 200);

    // descending ramp: 1000 -> 10 over 5 levels, 2 triggers each
    go(1000, 10, 5, 2);
    pulses(2);
    cmp("R3 descending", int'(dac_out), 753);
    // back-to-back triggers
    trig = 1'b1; repeat (6) tick(); trig = 1'b0; tick();
    cmp("R4 descending final", int'(dac_out), 10);
    pulses(2);

    // single level
    go(4242, 9999, 1, 2);
    pulses(1);
    cmp("R8 still running", int'(busy), 1);
    pulses(1);
    cmp("R8 finished at init", int'(done) * 100000 + int'(dac_out), 104242);

    // rejected configurations
    go(7, 8, 0, 4);
    cmp("R9 zero steps", int'(cfg_err), 1);
    cmp("R9 no load", int'(dac_out), 4242);
    go(7, 8, 3, 0);
    cmp("R9 zero events", int'(cfg_err), 1);
    pulses(2);
    abort = 1'b1; tick(); abort = 1'b0; tick();
    cmp("R9 cleared by abort", int'(cfg_err), 0);

    // abort mid-ramp, then abort with start
    go(0, 262143, 7, 1);
    pulses(3);
    abort = 1'b1; tick(); abort = 1'b0;
    cmp("R10 abort idle", int'(busy), 0);
    cmp("R10 level held", int'(dac_out), 131070);
    abort = 1'b1; start = 1'b1; tick(); abort = 1'b0; start = 1'b0; tick();
    cmp("R10 abort beats start", int'(busy), 0);
    go(0, 262143, 7, 1);
    trig = 1'b1; repeat (7) tick(); trig = 1'b0; tick();
    cmp("R4 full scale", int'(dac_out), 262143);
    tick(); tick();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule